// File: doc/BRIEF.md
# Compare-Immediate Branch Condition Unit

This unit decides a conditional branch that compares a register against a small immediate carried in the instruction. Each request brings a 64-bit register value, a 17-bit signed immediate, a 10-bit signed word displacement, a 3-bit condition code, a 2-bit precision code and the address of the branch instruction. One cycle later the unit returns a registered result. The result holds a taken flag, the branch target and the address the core should fetch next.

The comparison always puts the immediate first. For example, "greater-than" means the immediate is greater than the register. Before comparing, both operands are narrowed to the selected precision. A byte, halfword, word or doubleword compare is therefore available from the same opcode. After narrowing, signed conditions sign-extend both operands and all other conditions zero-extend them. The target is computed whether or not the branch is taken.

Top module: `cmpimm_branch_unit`

## Requirements
- R1: While `rst` is high on a clock edge, the next value of both `out_valid` and `out_taken` is 0.
- R2: `out_valid` is high in the cycle after a clock edge that saw `in_valid` high, and low after an edge that saw it low. `out_taken` is 0 whenever `out_valid` is 0.
- R3: The 17-bit `imm` is sign-extended to 64 bits before narrowing. For example, 17'h1FFFF equals a register of all ones at 64-bit precision.
- R4: Condition 0 is taken when the AND of immediate and register, within the precision, is zero. Condition 1 is taken when that AND is nonzero.
- R5: Condition 2 is taken when the immediate is signed-greater than the register. Condition 3 is taken when the immediate is signed less than or equal to the register.
- R6: Condition 4 is taken when the immediate is unsigned-greater than the register. Condition 5 is taken when the immediate is unsigned less than or equal to the register.
- R7: Condition 6 is taken when immediate and register are equal. Condition 7 is taken when they differ.
- R8: The precision code selects the compare width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Both operands are truncated to that width. Conditions 2 and 3 then sign-extend the operands, and all other conditions zero-extend them.
- R9: `out_target` equals `pc` plus the sign-extended `disp` shifted left by 2, taken modulo 2^64.
- R10: `out_next` equals `out_target` when the branch is taken, and `pc` + 4 when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| reg_val | input | 64 | Register operand |
| imm | input | 17 | Signed immediate |
| disp | input | 10 | Signed word displacement |
| cond | input | 3 | Condition code (0..7) |
| prec | input | 2 | Precision code (0..3) |
| pc | input | 64 | Address of the branch instruction |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Branch taken |
| out_target | output | 64 | Branch target address |
| out_next | output | 64 | Next fetch address |

## Verification
The clocked assertions assume that `in_valid` and the request fields are stable from one clock edge to the next. The bench meets this by changing inputs only on the falling edge. The assertions also assume that every condition and precision code is meaningful. Because all eight condition codes and all four precision codes are defined, any input value the bench drives lies within the legal space. The bench further places one idle cycle between requests, so the check that `out_valid` drops after an idle edge is exercised throughout the run.

// File: rtl/cmpimm_pkg.sv
package cmpimm_pkg;
    localparam int DATA_W = 64;
    localparam int IMM_W  = 17;
    localparam int DISP_W = 10;
    localparam int ADDR_W = 64;
    localparam int COND_W = 3;
    localparam int PREC_W = 2;
    localparam int NPREC  = 1 << PREC_W;
    localparam int BASE_W = 8;
    localparam int INSN_BYTES = 4;

    typedef enum logic [COND_W-1:0] {
        CC_BIT_CLR = 3'd0,
        CC_BIT_SET = 3'd1,
        CC_SGT     = 3'd2,
        CC_SLE     = 3'd3,
        CC_UGT     = 3'd4,
        CC_ULE     = 3'd5,
        CC_EQ      = 3'd6,
        CC_NE      = 3'd7
    } cmp_cond_e;

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [ADDR_W-1:0] target;
        logic [ADDR_W-1:0] next;
    } br_result_t;

    function automatic logic cond_is_signed(cmp_cond_e c);
        return (c == CC_SGT) || (c == CC_SLE);
    endfunction
endpackage

// File: rtl/cmpimm_narrow.sv
module cmpimm_narrow
    import cmpimm_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    input  logic [PREC_W-1:0] prec,
    input  logic              sign_en,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] cand [NPREC];

    for (genvar i = 0; i < NPREC; i++) begin : g_prec
        localparam int W = BASE_W << i;
        if (W >= DATA_W) begin : g_full
            assign cand[i] = data_in;
        end else begin : g_part
            logic fill;
            assign fill    = sign_en & data_in[W-1];
            assign cand[i] = {{(DATA_W-W){fill}}, data_in[W-1:0]};
        end
    end

    assign data_out = cand[prec];
endmodule

// File: rtl/cmpimm_eval.sv
module cmpimm_eval
    import cmpimm_pkg::*;
(
    input  logic [DATA_W-1:0] opa_imm,
    input  logic [DATA_W-1:0] opb_reg,
    input  cmp_cond_e         cond,
    output logic              imm_gt_s,
    output logic              imm_gt_u,
    output logic              ops_eq,
    output logic              and_zero,
    output logic              taken
);
    always_comb begin
        imm_gt_s = $signed(opa_imm) > $signed(opb_reg);
        imm_gt_u = opa_imm > opb_reg;
        ops_eq   = (opa_imm == opb_reg);
        and_zero = ((opa_imm & opb_reg) == '0);
        unique case (cond)
            CC_BIT_CLR: taken = and_zero;
            CC_BIT_SET: taken = !and_zero;
            CC_SGT:     taken = imm_gt_s;
            CC_SLE:     taken = !imm_gt_s;
            CC_UGT:     taken = imm_gt_u;
            CC_ULE:     taken = !imm_gt_u;
            CC_EQ:      taken = ops_eq;
            CC_NE:      taken = !ops_eq;
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmpimm_target.sv
module cmpimm_target
    import cmpimm_pkg::*;
(
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] fallthru
);
    localparam int SHIFT = $clog2(INSN_BYTES);
    logic [ADDR_W-1:0] offset;

    assign offset   = {{(ADDR_W-DISP_W-SHIFT){disp[DISP_W-1]}}, disp, {SHIFT{1'b0}}};
    assign target   = pc + offset;
    assign fallthru = pc + ADDR_W'(INSN_BYTES);
endmodule

// File: rtl/cmpimm_branch_unit.sv
module cmpimm_branch_unit
    import cmpimm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DISP_W-1:0] disp,
    input  logic [COND_W-1:0] cond,
    input  logic [PREC_W-1:0] prec,
    input  logic [ADDR_W-1:0] pc,
    output logic              out_valid,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_target,
    output logic [ADDR_W-1:0] out_next
);
    cmp_cond_e         cc;
    logic              sext_en;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] imm_n;
    logic [DATA_W-1:0] reg_n;
    logic              gt_s, gt_u, eq, az, hit;
    logic [ADDR_W-1:0] tgt, seq;
    br_result_t        res_d, res_q;

    assign cc       = cmp_cond_e'(cond);
    assign sext_en  = cond_is_signed(cc);
    assign imm_wide = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

    cmpimm_narrow u_nar_imm (
        .data_in (imm_wide),
        .prec    (prec),
        .sign_en (sext_en),
        .data_out(imm_n)
    );

    cmpimm_narrow u_nar_reg (
        .data_in (reg_val),
        .prec    (prec),
        .sign_en (sext_en),
        .data_out(reg_n)
    );

    cmpimm_eval u_eval (
        .opa_imm (imm_n),
        .opb_reg (reg_n),
        .cond    (cc),
        .imm_gt_s(gt_s),
        .imm_gt_u(gt_u),
        .ops_eq  (eq),
        .and_zero(az),
        .taken   (hit)
    );

    cmpimm_target u_tgt (
        .pc      (pc),
        .disp    (disp),
        .target  (tgt),
        .fallthru(seq)
    );

    always_comb begin
        res_d        = res_q;
        res_d.valid  = in_valid;
        res_d.taken  = in_valid & hit;
        if (in_valid) begin
            res_d.target = tgt;
            res_d.next   = hit ? tgt : seq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_taken  = res_q.taken;
    assign out_target = res_q.target;
    assign out_next   = res_q.next;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
    AST_TAKEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) out_taken |-> out_valid); // R2
    AST_TAKEN_USES_TARGET: assert property (@(posedge clk) disable iff (rst) (out_valid && out_taken) |-> (out_next == out_target)); // R10
    AST_FALLTHRU_ADDR: assert property (@(posedge clk) disable iff (rst) (in_valid && !hit) |=> (out_next == $past(pc) + 64'd4)); // R10
    AST_EQ_EXCLUDES_GT: assert property (@(posedge clk) disable iff (rst) eq |-> (!gt_s && !gt_u)); // R5
    AST_BITTEST_EXCL: assert property (@(posedge clk) disable iff (rst) (in_valid && cc == CC_BIT_SET) |-> (hit != az)); // R4
endmodule

// File: tb/cmpimm_branch_unit_tb.sv
module cmpimm_branch_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] reg_val;
    logic [16:0] imm;
    logic [9:0]  disp;
    logic [2:0]  cond;
    logic [1:0]  prec;
    logic [63:0] pc;
    logic        out_valid, out_taken;
    logic [63:0] out_target, out_next;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cmpimm_branch_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .reg_val(reg_val),
        .imm(imm), .disp(disp), .cond(cond), .prec(prec), .pc(pc),
        .out_valid(out_valid), .out_taken(out_taken),
        .out_target(out_target), .out_next(out_next)
    );

    function automatic logic model_taken(logic [63:0] r, logic [16:0] i,
                                         logic [2:0] c, logic [1:0] p);
        int w;
        logic [63:0] mask, a, b;
        logic sgn;
        w    = 8 << p;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        a    = {{47{i[16]}}, i} & mask;
        b    = r & mask;
        sgn  = (c == 3'd2) || (c == 3'd3);
        if (sgn && w < 64) begin
            if (a[w-1]) a = a | ~mask;
            if (b[w-1]) b = b | ~mask;
        end
        case (c)
            3'd0: return (a & b) == 0;
            3'd1: return (a & b) != 0;
            3'd2: return $signed(a) > $signed(b);
            3'd3: return $signed(a) <= $signed(b);
            3'd4: return a > b;
            3'd5: return a <= b;
            3'd6: return a == b;
            default: return a != b;
        endcase
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_br(string tag, logic [63:0] r, logic [16:0] i,
                          logic [9:0] d, logic [2:0] c, logic [1:0] p,
                          logic [63:0] a);
        logic        exp_t;
        logic [63:0] exp_tgt;
        @(negedge clk);
        in_valid = 1'b1; reg_val = r; imm = i; disp = d; cond = c; prec = p; pc = a;
        exp_t   = model_taken(r, i, c, p);
        exp_tgt = a + {{52{d[9]}}, d, 2'b00};
        @(negedge clk);
        in_valid = 1'b0;
        check64({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
        check64({tag, " taken"}, {63'd0, out_taken}, {63'd0, exp_t});
        check64({tag, " R9 target"}, out_target, exp_tgt);
        check64({tag, " R10 next"}, out_next, exp_t ? exp_tgt : a + 64'd4);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1;
        reg_val = '0; imm = '0; disp = '0; cond = 3'd6; prec = 2'd3; pc = '0;
        repeat (3) @(negedge clk);
        check64("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        check64("R1 taken in reset", {63'd0, out_taken}, 64'd0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_bittest();
        run_br("R4 clr hit", 64'hF0, 17'h0F, 10'd3, 3'd0, 2'd3, 64'h1000);
        run_br("R4 set miss", 64'hF0, 17'h0F, 10'd3, 3'd1, 2'd3, 64'h1000);
        run_br("R4 set hit", 64'h18, 17'h08, 10'd3, 3'd1, 2'd3, 64'h2000);
        run_br("R4 R8 high bits masked", 64'h100, 17'h1FF00, 10'd1, 3'd1, 2'd0, 64'h40);
    endtask

    task automatic t_signext();
        run_br("R3 all ones eq", 64'hFFFF_FFFF_FFFF_FFFF, 17'h1FFFF, 10'd2, 3'd6, 2'd3, 64'h100);
        run_br("R3 R6 neg imm ugt", 64'd5, 17'h1FFFF, 10'd2, 3'd4, 2'd3, 64'h100);
    endtask

    task automatic t_signed();
        run_br("R5 sgt hit", 64'hFFFF_FFFF_FFFF_FFFD, 17'd5, 10'd4, 3'd2, 2'd3, 64'h300);
        run_br("R5 sle miss", 64'hFFFF_FFFF_FFFF_FFFD, 17'd5, 10'd4, 3'd3, 2'd3, 64'h300);
        run_br("R5 sle equal", 64'd7, 17'd7, 10'd4, 3'd3, 2'd3, 64'h300);
        run_br("R5 sgt equal", 64'd7, 17'd7, 10'd4, 3'd2, 2'd3, 64'h300);
    endtask

    task automatic t_unsigned();
        run_br("R6 ugt miss", 64'hFFFF_FFFF_FFFF_FFFD, 17'd5, 10'd8, 3'd4, 2'd3, 64'h500);
        run_br("R6 ule hit", 64'hFFFF_FFFF_FFFF_FFFD, 17'd5, 10'd8, 3'd5, 2'd3, 64'h500);
    endtask

    task automatic t_equal();
        run_br("R7 eq miss", 64'd9, 17'd8, 10'd5, 3'd6, 2'd3, 64'h600);
        run_br("R7 ne hit", 64'd9, 17'd8, 10'd5, 3'd7, 2'd3, 64'h600);
    endtask

    task automatic t_precision();
        run_br("R8 byte eq low zero", 64'h100, 17'd0, 10'd6, 3'd6, 2'd0, 64'h700);
        run_br("R8 half eq miss", 64'h100, 17'd0, 10'd6, 3'd6, 2'd1, 64'h700);
        run_br("R8 byte sgt", 64'h80, 17'd0, 10'd6, 3'd2, 2'd0, 64'h700);
        run_br("R8 byte ugt", 64'h80, 17'd0, 10'd6, 3'd4, 2'd0, 64'h700);
        run_br("R8 imm trunc", 64'hFF, 17'h1FF, 10'd6, 3'd6, 2'd0, 64'h700);
        run_br("R8 word sle", 64'hAAAA_AAAA_8000_0000, 17'h10000, 10'd6, 3'd3, 2'd2, 64'h700);
    endtask

    task automatic t_target();
        run_br("R9 neg disp", 64'd1, 17'd1, 10'h3FF, 3'd6, 2'd3, 64'h1000);
        check64("R9 neg disp literal", out_target, 64'h0FFC);
        run_br("R9 max disp", 64'd1, 17'd1, 10'h1FF, 3'd6, 2'd3, 64'h1000);
        check64("R9 max disp literal", out_target, 64'h17FC);
        run_br("R9 wrap", 64'd1, 17'd1, 10'h3FF, 3'd6, 2'd3, 64'h0);
        check64("R9 wrap literal", out_target, 64'hFFFF_FFFF_FFFF_FFFC);
        run_br("R10 fallthru", 64'd1, 17'd2, 10'h3FF, 3'd6, 2'd3, 64'h1000);
        check64("R10 fallthru literal", out_next, 64'h1004);
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0; cond = 3'd7; imm = 17'd1; reg_val = 64'd2;
        @(negedge clk);
        check64("R2 idle valid", {63'd0, out_valid}, 64'd0);
        check64("R2 idle taken", {63'd0, out_taken}, 64'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_bittest();
                t_signext();
                t_signed();
                t_unsigned();
                t_equal();
                t_precision();
                t_target();
                t_idle();
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule